// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block keeps an asynchronous DRAM refreshed from a synchronous system clock. Every datasheet-style time limit is a parameter in nanoseconds, microseconds or milliseconds. The block turns each one into a whole number of clock cycles, rounding towards the safe side. After reset it waits out the power-up pause. It then runs a burst of refresh cycles before any host access may start. From then on it raises a refresh at a fixed interval, derived from the number of rows and the retention period.

The block shares the DRAM pins with a host access engine through a request/grant pair. The host holds `host_req` high for as long as its cycle lasts, and it may drive the pins only while `host_gnt` is high. When the block owns the pins, `ref_busy` is high and the data pins must stay high impedance.

Two refresh styles are available, selected by `use_cbr` when each cycle starts:
- **CAS-before-RAS:** the DRAM uses its internal row counter.
- **RAS-only:** the block drives the row address from its own wrapping counter.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, ras_n, cas_n and we_n are 1, and host_gnt, ref_busy and init_done are 0. After reset is released, no RAS or CAS activity occurs for the power-up pause (20000 cycles at the defaults). The first RAS fall then comes no more than 10 cycles after the pause.
- R2: After the pause, exactly INIT_CYCLES (8) refresh cycles run back to back. init_done rises after the last of them and stays high until reset. host_gnt is never 1 while init_done is 0.
- R3: In a CAS-before-RAS cycle (use_cbr=1), cas_n is low for exactly 2 cycles before ras_n falls. It stays low for exactly 2 cycles starting with the RAS fall, so it is low for 4 cycles in total. we_n stays 1 at all times. If use_cbr is 1, all initialisation cycles are of this type.
- R4: In a RAS-only cycle (use_cbr=0), cas_n stays 1 and row_addr_en is 1 while ras_n is low. row_addr does not change while ras_n is low.
- R5: Every refresh holds ras_n low for exactly 10 cycles. Between two refresh pulses ras_n is high for at least 8 cycles. Two consecutive RAS falls are at least 18 cycles apart.
- R6: With no host traffic, consecutive periodic refresh RAS falls are exactly floor(REFRESH_US*10^6 / 2^ROW_W / CLK_PS) cycles apart. At the defaults this is 3125 cycles.
- R7: Once initialisation is done, with no refresh pending and the sequencer idle, host_gnt rises one cycle after host_req is high. It stays high while host_req stays high, and it falls one cycle after host_req falls.
- R8: A refresh that falls due during a host grant waits until host_req drops. It then starts before any new grant, even if host_req is raised again at once. ras_n and cas_n stay 1 while host_gnt is 1.
- R9: The RAS-only row counter starts at 0 after reset and advances by one after each completed RAS-only cycle. It wraps from 2047 to 0. CAS-before-RAS cycles leave it unchanged.
- R10: host_gnt and ref_busy are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_PS picoseconds |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| use_cbr | input | 1 | 1 selects CAS-before-RAS refresh, 0 selects RAS-only; sampled when each cycle starts |
| host_req | input | 1 | Host engine wants the DRAM pins; held for its whole cycle |
| host_gnt | output | 1 | Host may drive the DRAM pins |
| ref_busy | output | 1 | Refresh owns the pins; data pins must be high impedance |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for RAS-only refresh |
| row_addr_en | output | 1 | row_addr must be driven onto the address pins |
| init_done | output | 1 | Initialisation burst has finished |

## Verification
The assertions watch the following on every cycle:
- the mutual exclusion of grant and refresh, and the quiet strobes during a grant;
- the grant hold and release;
- the exact RAS low width;
- CAS being low at a CAS-before-RAS fall;
- CAS staying high and the row address holding still in RAS-only cycles.

Other behaviours need whole timelines, so only the bench scenarios show them:
- the power-up pause length and the count of initialisation cycles;
- the exact refresh interval;
- a refresh deferred behind a long host cycle and taking priority afterwards;
- the row counter ignoring CAS-before-RAS cycles and wrapping after 2048 RAS-only cycles.

// File: rtl/dref_pkg.sv
`timescale 1ns/1ps
package dref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CSR  = 2'd1,
    SQ_ACT  = 2'd2,
    SQ_PRE  = 2'd3
  } sq_state_e;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_rst_sync.sv
`timescale 1ns/1ps
module dref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/dref_interval.sv
`timescale 1ns/1ps
module dref_interval #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == W'(LIMIT - 1));
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dref_seq.sv
`timescale 1ns/1ps
module dref_seq import dref_pkg::*; #(
  parameter int unsigned CSR_CYC = 2,
  parameter int unsigned RAS_CYC = 10,
  parameter int unsigned CHR_CYC = 2,
  parameter int unsigned PRE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cbr_sel,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic addr_en
);
  localparam int unsigned MAXC  = umax(umax(CSR_CYC, RAS_CYC), PRE_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  sq_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cbr_q, cbr_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cbr_d = cbr_q;
    case (st_q)
      SQ_IDLE: if (start) begin
        cbr_d = cbr_sel;
        if (cbr_sel) begin
          st_d  = SQ_CSR;
          cnt_d = CNT_W'(CSR_CYC - 1);
        end else begin
          st_d  = SQ_ACT;
          cnt_d = CNT_W'(RAS_CYC - 1);
        end
      end
      SQ_CSR: if (cnt_q == '0) begin
        st_d  = SQ_ACT;
        cnt_d = CNT_W'(RAS_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      SQ_ACT: if (cnt_q == '0) begin
        st_d  = SQ_PRE;
        cnt_d = CNT_W'(PRE_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      SQ_PRE: if (cnt_q == '0) st_d = SQ_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      cbr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cbr_q <= cbr_d;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign done    = (st_q == SQ_PRE) && (cnt_q == '0);
  assign ras_n   = (st_q != SQ_ACT);
  assign cas_n   = !((st_q == SQ_CSR) ||
                     ((st_q == SQ_ACT) && cbr_q && (cnt_q >= CNT_W'(RAS_CYC - CHR_CYC))));
  assign addr_en = !cbr_q && ((st_q == SQ_ACT) || (st_q == SQ_PRE));
endmodule

// File: rtl/dref_rowctr.sv
`timescale 1ns/1ps
module dref_rowctr #(
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb row_d = adv ? row_q + 1'b1 : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched import dref_pkg::*; #(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned ROW_W       = 11,
  parameter int unsigned REFRESH_US  = 32000,
  parameter int unsigned PAUSE_US    = 100,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned T_RAS_NS    = 50,
  parameter int unsigned T_RP_NS     = 30,
  parameter int unsigned T_RC_NS     = 90,
  parameter int unsigned T_CSR_NS    = 10,
  parameter int unsigned T_CHR_NS    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_cbr,
  input  logic             host_req,
  output logic             host_gnt,
  output logic             ref_busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_addr_en,
  output logic             init_done
);
  localparam longint      ROWS      = longint'(1) << ROW_W;
  localparam int unsigned CSR_CYC   = ns_to_cyc(T_CSR_NS, CLK_PS);
  localparam int unsigned RAS_CYC   = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int unsigned CHR_RAW   = ns_to_cyc(T_CHR_NS, CLK_PS);
  localparam int unsigned CHR_CYC   = (CHR_RAW > RAS_CYC) ? RAS_CYC : CHR_RAW;
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PS);
  localparam int unsigned RC_REST   = (RC_CYC > RAS_CYC) ? RC_CYC - RAS_CYC : 1;
  localparam int unsigned PRE_CYC   = umax(RP_CYC, RC_REST);
  localparam longint      INT_RAW   = (longint'(REFRESH_US) * 1000000) / ROWS / CLK_PS;
  localparam int unsigned INT_CYC   = (INT_RAW < 1) ? 1 : int'(INT_RAW);
  localparam longint      PAUSE_RAW = (longint'(PAUSE_US) * 1000000 + CLK_PS - 1) / CLK_PS;
  localparam int unsigned PAUSE_CYC = (PAUSE_RAW < 1) ? 1 : int'(PAUSE_RAW);
  localparam int unsigned INIT_N    = (INIT_CYCLES < 1) ? 1 : INIT_CYCLES;
  localparam int unsigned INIT_W    = $clog2(INIT_N + 1);

  logic              rst_i_n;
  logic              pause_tick, ref_tick;
  logic              seq_busy, seq_done, seq_addr_en, start_ref;
  logic              pause_done_q, pause_done_d;
  logic              init_done_q, init_done_d;
  logic [INIT_W-1:0] init_cnt_q, init_cnt_d;
  logic              pend_q, pend_d;
  logic              gnt_q, gnt_d;

  dref_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  dref_interval #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_i_n), .en(!pause_done_q), .tick(pause_tick));

  dref_interval #(.LIMIT(INT_CYC)) u_ival (
    .clk(clk), .rst_n(rst_i_n), .en(init_done_q), .tick(ref_tick));

  dref_seq #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .CHR_CYC(CHR_CYC), .PRE_CYC(PRE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start_ref), .cbr_sel(use_cbr),
    .busy(seq_busy), .done(seq_done), .ras_n(ras_n), .cas_n(cas_n), .addr_en(seq_addr_en));

  dref_rowctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_i_n), .adv(seq_done && seq_addr_en), .row(row_addr));

  // A refresh may start only with the pins free: no grant held and sequencer idle.
  always_comb begin
    start_ref    = !seq_busy && !gnt_q && pause_done_q && (!init_done_q || pend_q);
    pause_done_d = pause_done_q | pause_tick;
    init_cnt_d   = init_cnt_q;
    init_done_d  = init_done_q;
    if (seq_done && !init_done_q) begin
      init_cnt_d = init_cnt_q + 1'b1;
      if (init_cnt_q == INIT_W'(INIT_N - 1)) init_done_d = 1'b1;
    end
    pend_d = ref_tick | (pend_q & !(start_ref & init_done_q));
    if (gnt_q) gnt_d = host_req;
    else       gnt_d = host_req && init_done_q && !seq_busy && !pend_q && !start_ref;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pause_done_q <= 1'b0;
      init_done_q  <= 1'b0;
      init_cnt_q   <= '0;
      pend_q       <= 1'b0;
      gnt_q        <= 1'b0;
    end else begin
      pause_done_q <= pause_done_d;
      init_done_q  <= init_done_d;
      init_cnt_q   <= init_cnt_d;
      pend_q       <= pend_d;
      gnt_q        <= gnt_d;
    end
  end

  assign host_gnt    = gnt_q;
  assign ref_busy    = seq_busy;
  assign we_n        = 1'b1;
  assign row_addr_en = seq_addr_en;
  assign init_done   = init_done_q;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
`timescale 1ns/1ps
module dram_refresh_sched_chk import dref_pkg::*; #(
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned T_RAS_NS = 50,
  parameter int unsigned ROW_W    = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_gnt,
  input logic             ref_busy,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             row_addr_en,
  input logic             init_done
);
  localparam int unsigned RAS_CYC = ns_to_cyc(T_RAS_NS, CLK_PS);

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else        low_cnt <= ras_n ? 16'd0 : low_cnt + 16'd1;
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && ref_busy));

  p_quiet_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (ras_n && cas_n));

  p_no_early_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !host_gnt);

  p_init_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_gnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && host_req) |=> host_gnt);

  p_gnt_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> !host_gnt);

  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt == 16'(RAS_CYC)));

  p_cbr_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !row_addr_en) |-> !cas_n);

  p_rasonly_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && row_addr_en) |-> cas_n);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n) && row_addr_en) |-> $stable(row_addr));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .CLK_PS(CLK_PS), .T_RAS_NS(T_RAS_NS), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_gnt(host_gnt),
  .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
  .row_addr_en(row_addr_en), .init_done(init_done)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int PAUSE = 20000;
  localparam int INTV  = 3125;
  localparam int INIT  = 8;
  localparam int RAS   = 10;
  localparam int PRE   = 8;
  localparam int RC    = 18;
  localparam int CSR   = 2;
  localparam int CHR   = 2;
  localparam int ROWS  = 2048;
  // host grant scenarios: {request length in cycles, idle gap after}
  localparam int HOST_TAB [4][2] = '{'{1, 3}, '{2, 1}, '{5, 2}, '{12, 4}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, use_cbr, host_req;
  logic host_gnt, ref_busy, ras_n, cas_n, we_n, row_addr_en, init_done;
  logic [10:0] row_addr;
  logic w_gnt, w_busy, w_ras_n, w_cas_n, w_we_n, w_addr_en, w_init;
  logic [10:0] w_addr;

  dram_refresh_sched dut (
    .clk(clk), .rst_n(rst_n), .use_cbr(use_cbr), .host_req(host_req),
    .host_gnt(host_gnt), .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row_addr), .row_addr_en(row_addr_en), .init_done(init_done));

  dram_refresh_sched #(.REFRESH_US(80), .PAUSE_US(1)) dut_w (
    .clk(clk), .rst_n(rst_n), .use_cbr(1'b0), .host_req(1'b0),
    .host_gnt(w_gnt), .ref_busy(w_busy), .ras_n(w_ras_n), .cas_n(w_cas_n),
    .we_n(w_we_n), .row_addr(w_addr), .row_addr_en(w_addr_en), .init_done(w_init));

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor of the main instance, sampled 1 ns after each rising edge.
  int fall_t [64];
  bit fall_cbr [64];
  logic [10:0] fall_addr [64];
  int nfall = 0, ras_low = 0, ras_high = 0, cas_run = 0;
  logic p_ras = 1'b1, p_cas = 1'b1;
  int v_ras_w = 0, v_pre = 0, v_rc = 0, v_csr = 0, v_chr = 0, v_rocas = 0, v_we = 0;
  int v_gntbusy = 0, v_gnt_pre = 0;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      nfall = 0; ras_low = 0; ras_high = 0; cas_run = 0; p_ras = 1'b1; p_cas = 1'b1;
    end else begin
      if (!ras_n && p_ras) begin
        if (nfall > 0 && ras_high < PRE) v_pre++;
        if (nfall > 0 && (cyc - fall_t[(nfall - 1) % 64]) < RC) v_rc++;
        if (!row_addr_en && (cas_n || cas_run != CSR)) v_csr++;
        fall_t[nfall % 64]    = cyc;
        fall_cbr[nfall % 64]  = !row_addr_en;
        fall_addr[nfall % 64] = row_addr;
        nfall++;
      end
      if (ras_n && !p_ras && ras_low != RAS) v_ras_w++;
      if (cas_n && !p_cas && nfall > 0 && fall_cbr[(nfall - 1) % 64] && cas_run != CSR + CHR) v_chr++;
      if (row_addr_en && !ras_n && !cas_n) v_rocas++;
      if (!we_n) v_we++;
      if (host_gnt && (ref_busy || !ras_n || !cas_n)) v_gntbusy++;
      if (host_gnt && !init_done) v_gnt_pre++;
      ras_low  = !ras_n ? ras_low + 1 : 0;
      ras_high = ras_n ? ras_high + 1 : 0;
      cas_run  = !cas_n ? cas_run + 1 : 0;
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  // Monitor of the wrap instance: RAS-only rows must run 0,1,2,... modulo 2048.
  int wn = 0, wbad = 0;
  bit wrapped = 1'b0;
  logic wp_ras = 1'b1;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      wn = 0; wp_ras = 1'b1;
    end else begin
      if (!w_ras_n && wp_ras) begin
        if (!w_addr_en || w_addr != 11'(wn % ROWS)) wbad++;
        if (wn == ROWS && w_addr == 11'd0) wrapped = 1'b1;
        wn++;
      end
      wp_ras = w_ras_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rel, last, n0, lim;
    bit gnt_seen;
    rst_n = 1'b0; use_cbr = 1'b1; host_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!host_gnt && !ref_busy && !init_done, "R1 flags in reset",
        {host_gnt, ref_busy, init_done}, 0);
    host_req = 1'b1;
    rst_n = 1'b1;
    rel = cyc;
    repeat (PAUSE - 5) @(negedge clk);
    chk(nfall == 0, "R1 quiet during pause", nfall, 0);
    chk(!host_gnt, "R2 no grant before init", host_gnt, 0);
    lim = 0;
    while (!init_done && lim < 1000) begin @(negedge clk); lim++; end
    chk(nfall == INIT, "R2 init burst count", nfall, INIT);
    chk(fall_t[0] - rel >= PAUSE && fall_t[0] - rel <= PAUSE + 10, "R1 first refresh after pause",
        fall_t[0] - rel, PAUSE);
    n0 = 0;
    for (int i = 0; i < INIT; i++) n0 += fall_cbr[i];
    chk(n0 == INIT, "R3 init cycles all CAS-before-RAS", n0, INIT);
    // R7: grant follows init_done by one cycle with host_req held high
    chk(!host_gnt, "R7 grant not yet", host_gnt, 0);
    @(negedge clk);
    chk(host_gnt, "R7 grant after init", host_gnt, 1);
    repeat (3) @(negedge clk);
    chk(host_gnt, "R7 grant held", host_gnt, 1);
    host_req = 1'b0;
    @(negedge clk);
    chk(!host_gnt, "R7 grant released", host_gnt, 0);
    // R7: table of host request lengths
    for (int k = 0; k < 4; k++) begin
      host_req = 1'b1;
      @(negedge clk);
      chk(host_gnt, "R7 table grant rise", host_gnt, 1);
      for (int j = 1; j < HOST_TAB[k][0]; j++) begin
        @(negedge clk);
        chk(host_gnt, "R7 table grant hold", host_gnt, 1);
      end
      host_req = 1'b0;
      @(negedge clk);
      chk(!host_gnt, "R7 table grant fall", host_gnt, 0);
      repeat (HOST_TAB[k][1]) @(negedge clk);
    end
    // R6: periodic interval
    while (nfall < INIT + 3) @(negedge clk);
    chk(fall_t[9] - fall_t[8] == INTV, "R6 interval a", fall_t[9] - fall_t[8], INTV);
    chk(fall_t[10] - fall_t[9] == INTV, "R6 interval b", fall_t[10] - fall_t[9], INTV);
    chk(fall_cbr[8] && fall_cbr[10], "R3 periodic type", {fall_cbr[8], fall_cbr[10]}, 3);
    // R8: refresh deferred behind a long host cycle, then wins the re-request
    last = fall_t[10];
    while (cyc < last + INTV - 30) @(negedge clk);
    host_req = 1'b1;
    @(negedge clk);
    chk(host_gnt, "R8 host granted", host_gnt, 1);
    n0 = nfall;
    while (cyc < last + INTV + 60) @(negedge clk);
    chk(nfall == n0, "R8 refresh deferred", nfall, n0);
    host_req = 1'b0;
    @(negedge clk);
    host_req = 1'b1;
    gnt_seen = 1'b0;
    for (int j = 0; j < 10 && nfall == n0; j++) begin
      @(negedge clk);
      if (host_gnt) gnt_seen = 1'b1;
    end
    chk(nfall == n0 + 1, "R8 refresh runs after host", nfall, n0 + 1);
    chk(!gnt_seen, "R8 refresh before new grant", gnt_seen, 0);
    lim = 0;
    while (!host_gnt && lim < 40) begin @(negedge clk); lim++; end
    chk(host_gnt && !ref_busy, "R8 host regains pins", {host_gnt, ref_busy}, 2);
    host_req = 1'b0;
    // R9: counter untouched by CAS-before-RAS cycles
    @(negedge clk);
    use_cbr = 1'b0;
    n0 = nfall;
    while (nfall < n0 + 2) @(negedge clk);
    chk(!fall_cbr[n0 % 64] && fall_addr[n0 % 64] == 0, "R9 first RAS-only row", fall_addr[n0 % 64], 0);
    chk(!fall_cbr[(n0 + 1) % 64] && fall_addr[(n0 + 1) % 64] == 1, "R9 second RAS-only row",
        fall_addr[(n0 + 1) % 64], 1);
    repeat (20) @(negedge clk);
    // timing rules collected over the whole run
    chk(v_csr == 0, "R3 CAS setup before RAS", v_csr, 0);
    chk(v_chr == 0, "R3 CAS hold after RAS", v_chr, 0);
    chk(v_we == 0, "R3 WE high", v_we, 0);
    chk(v_rocas == 0, "R4 CAS high in RAS-only", v_rocas, 0);
    chk(v_ras_w == 0, "R5 RAS low width", v_ras_w, 0);
    chk(v_pre == 0, "R5 RAS precharge", v_pre, 0);
    chk(v_rc == 0, "R5 cycle time", v_rc, 0);
    chk(v_gntbusy == 0, "R10 grant exclusive of refresh", v_gntbusy, 0);
    chk(v_gnt_pre == 0, "R2 grant only after init", v_gnt_pre, 0);
    chk(init_done, "R2 init_done sticky", init_done, 1);
    // R9: wrap on the fast instance
    while (wn < ROWS + 3) @(negedge clk);
    chk(wrapped, "R9 row wraps 2047 to 0", wrapped, 1);
    chk(wbad == 0, "R9 consecutive rows", wbad, 0);
    chk(w_init, "R2 wrap instance init", w_init, 1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule